// File: doc/BRIEF.md
# Open-Page SDRAM Read Command Sequencer

This block turns read requests into the command sequence a DDR SDRAM device expects when rows are left open between accesses. It records which row is currently open and compares each incoming request's row against it. A request to the open row (a page hit) gets its column read command in the very next cycle. A request to a different row (a page miss) first closes the open row with a precharge, waits the row-precharge time, opens the new row with an activate, waits the activate-to-read time, and then sends the read. After reset no row is open, so the first request opens its row without a precharge.

Requests arrive on a valid/ready handshake. A request is taken only in a cycle where both `req_valid` and `req_ready` are high. While the sequencer is counting a precharge or activate wait, `req_ready` stays low, and the requester must hold its row and column stable until it is taken. The read data window is flagged by `rd_valid`. It starts a CAS-latency number of cycles after each read command and normally lasts one burst. A read command issued before the previous burst has finished cuts that burst short and starts a fresh one. Both timing waits and the CAS latency are plain control inputs.

Top module: `sdram_rd_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the strobes are all high (NOP), `addr` is 0, `req_ready` is high and `rd_valid` is low.
- R2: With no row open, an accepted request produces, in the next cycle, an activate with {ras_n,cas_n,we_n} = 011 and the request's row on `addr`. No precharge comes first.
- R3: After an activate, the read command {ras_n,cas_n,we_n} = 101 with the request's column on `addr` follows `t_rcd` cycles later.
- R4: A request whose row equals the open row produces the read command in the cycle after acceptance, with no precharge and no activate.
- R5: A request to a row other than the open one produces a precharge {ras_n,cas_n,we_n} = 010 in the cycle after acceptance, and then an activate of the new row `t_rp` cycles after the precharge.
- R6: A `t_rp` or `t_rcd` value of 0 behaves as a value of 1.
- R7: `req_ready` is low from the cycle after a miss is accepted until the cycle of its read command, and high in that read cycle.
- R8: `rd_valid` first rises `cas_lat` cycles after a read command (`cas_lat` of 2 and 3 supported), with `rd_first` high in that cycle, and then stays high for BURST_LEN cycles.
- R9: A read command issued while a burst is still in progress truncates it. `rd_valid` stays high without a gap, `rd_first` marks the new burst, and the window ends BURST_LEN cycles after the new first beat.
- R10: In every cycle with no command, the strobes are 111 and `addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| t_rp | input | 4 | Precharge-to-activate wait in cycles |
| t_rcd | input | 4 | Activate-to-read wait in cycles |
| cas_lat | input | 3 | Read-command-to-first-data latency (2..MAX_CL) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can take a request this cycle |
| req_row | input | 14 | Row of the request |
| req_col | input | 14 | Column of the request |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write-enable strobe, active low |
| addr | output | 14 | Multiplexed row/column address |
| rd_valid | output | 1 | Read data beat expected this cycle |
| rd_first | output | 1 | First beat of a burst |

## Verification
The bench goes after the hit/miss decision right after reset, where a design that trusts a stale row register would emit a needless precharge or a read with no activate. It sweeps `t_rp` and `t_rcd` down to zero, where an off-by-one counter would issue the activate or read a cycle early or late, or would wrap around and stall for sixteen cycles. It issues back-to-back reads to check truncation: a design that waits out the old burst would leave a gap in `rd_valid`, and one that misses the restart would drop `rd_valid` too early. It also runs both CAS latencies, where a fixed pipe tap would shift the data window.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;
  localparam int ADDR_W = 14;

  // Encoded as {ras_n, cas_n, we_n}
  typedef enum logic [2:0] {
    CMD_NOP = 3'b111,
    CMD_ACT = 3'b011,
    CMD_RD  = 3'b101,
    CMD_PRE = 3'b010
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_PRE_WAIT = 2'd1,
    ST_RCD_WAIT = 2'd2
  } seq_st_e;
endpackage

// File: rtl/sdram_row_track.sv
module sdram_row_track #(
  parameter int ROW_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_fire,
  input  logic             pre_fire,
  input  logic [ROW_W-1:0] act_row,
  input  logic [ROW_W-1:0] cmp_row,
  output logic             row_open,
  output logic             row_hit
);
  logic [ROW_W-1:0] open_row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_open   <= 1'b0;
      open_row_q <= '0;
    end else if (act_fire) begin
      row_open   <= 1'b1;
      open_row_q <= act_row;
    end else if (pre_fire) begin
      row_open   <= 1'b0;
    end
  end

  assign row_hit = row_open && (open_row_q == cmp_row);
endmodule

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load)       cnt_q <= load_val;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sdram_rd_lat.sv
module sdram_rd_lat #(
  parameter int MAX_CL    = 4,
  parameter int BURST_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_cmd,
  input  logic [2:0] cas_lat,
  output logic       rd_valid,
  output logic       rd_first
);
  localparam int BW = $clog2(BURST_LEN + 1);
  localparam logic [BW-1:0] BEATS_M1 = BW'(BURST_LEN - 1);
  localparam logic [2:0] CL_HI = 3'(MAX_CL);

  logic [MAX_CL:1] sh_q;
  logic [BW-1:0]   left_q;
  logic [2:0]      cl_eff;

  always_comb begin
    if (cas_lat < 3'd2)      cl_eff = 3'd2;
    else if (cas_lat > CL_HI) cl_eff = CL_HI;
    else                      cl_eff = cas_lat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[MAX_CL-1:1], rd_cmd};
  end

  assign rd_first = sh_q[cl_eff];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            left_q <= '0;
    else if (rd_first)     left_q <= BEATS_M1;
    else if (left_q != '0) left_q <= left_q - 1'b1;
  end

  assign rd_valid = rd_first || (left_q != '0);

  // R8
  first_beat_leads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> rd_first);
endmodule

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq
  import sdram_rd_pkg::*;
#(
  parameter int TW        = 4,
  parameter int MAX_CL    = 4,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TW-1:0]     t_rp,
  input  logic [TW-1:0]     t_rcd,
  input  logic [2:0]        cas_lat,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_row,
  input  logic [ADDR_W-1:0] req_col,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic              rd_valid,
  output logic              rd_first
);
  seq_st_e           st_q, st_d;
  cmd_e              cmd_q, cmd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] row_q, col_q;
  logic              accept, row_open, row_hit, tmr_zero, tmr_load;
  logic [TW-1:0]     tmr_val, rp_ld, rcd_ld;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign rp_ld     = (t_rp  == '0) ? '0 : t_rp  - 1'b1;
  assign rcd_ld    = (t_rcd == '0) ? '0 : t_rcd - 1'b1;

  sdram_row_track #(.ROW_W(ADDR_W)) u_track (
    .clk(clk), .rst_n(rst_n),
    .act_fire(cmd_d == CMD_ACT), .pre_fire(cmd_d == CMD_PRE),
    .act_row(addr_d), .cmp_row(req_row),
    .row_open(row_open), .row_hit(row_hit)
  );

  sdram_gap_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  always_comb begin
    st_d     = st_q;
    cmd_d    = CMD_NOP;
    addr_d   = '0;
    tmr_load = 1'b0;
    tmr_val  = rcd_ld;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        if (row_hit) begin
          cmd_d  = CMD_RD;
          addr_d = req_col;
        end else if (row_open) begin
          cmd_d    = CMD_PRE;
          st_d     = ST_PRE_WAIT;
          tmr_load = 1'b1;
          tmr_val  = rp_ld;
        end else begin
          cmd_d    = CMD_ACT;
          addr_d   = req_row;
          st_d     = ST_RCD_WAIT;
          tmr_load = 1'b1;
        end
      end
      ST_PRE_WAIT: if (tmr_zero) begin
        cmd_d    = CMD_ACT;
        addr_d   = row_q;
        st_d     = ST_RCD_WAIT;
        tmr_load = 1'b1;
      end
      ST_RCD_WAIT: if (tmr_zero) begin
        cmd_d  = CMD_RD;
        addr_d = col_q;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
    end else begin
      st_q   <= st_d;
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
      if (accept) begin
        row_q <= req_row;
        col_q <= req_col;
      end
    end
  end

  assign {ras_n, cas_n, we_n} = cmd_q;
  assign addr = addr_q;

  sdram_rd_lat #(.MAX_CL(MAX_CL), .BURST_LEN(BURST_LEN)) u_lat (
    .clk(clk), .rst_n(rst_n), .rd_cmd(cmd_q == CMD_RD), .cas_lat(cas_lat),
    .rd_valid(rd_valid), .rd_first(rd_first)
  );

  // R4
  hit_reads_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && row_hit) |=> (cmd_q == CMD_RD));
  // R2
  closed_row_no_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !row_open) |=> (cmd_q == CMD_ACT));
  // R5
  pre_then_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_PRE) |=> (cmd_q == CMD_NOP || cmd_q == CMD_ACT));
  // R7
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_PRE || cmd_q == CMD_ACT) |-> !req_ready);
endmodule

// File: tb/test_sdram_rd_seq.sv
module test_sdram_rd_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] t_rp = 4'd3, t_rcd = 4'd3;
  logic [2:0] cas_lat = 3'd2;
  logic req_valid = 1'b0;
  logic [13:0] req_row = '0, req_col = '0;
  logic req_ready, ras_n, cas_n, we_n, rd_valid, rd_first;
  logic [13:0] addr;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sdram_rd_seq i_sdram_rd_seq (
    .clk(clk), .rst_n(rst_n), .t_rp(t_rp), .t_rcd(t_rcd), .cas_lat(cas_lat),
    .req_valid(req_valid), .req_ready(req_ready), .req_row(req_row), .req_col(req_col),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr),
    .rd_valid(rd_valid), .rd_first(rd_first)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // strobes+addr packed: {ras,cas,we,addr}
  function automatic logic [31:0] bus();
    return {15'd0, ras_n, cas_n, we_n, addr};
  endfunction

  function automatic logic [31:0] mk(input logic [2:0] s, input logic [13:0] a);
    return {15'd0, s, a};
  endfunction

  task automatic send(input logic [13:0] r, input logic [13:0] c);
    while (!req_ready) step();
    req_valid = 1; req_row = r; req_col = c;
    step();
    req_valid = 0;
  endtask

  task automatic drain();
    repeat (10) step();
  endtask

  task automatic t_reset();
    chk("R1 strobes during reset", bus(), mk(3'b111, 0));
    chk("R1 ready during reset", 32'(req_ready), 1);
    rst_n = 1; step();
    chk("R1 strobes after reset", bus(), mk(3'b111, 0));
    chk("R1 rd_valid after reset", 32'(rd_valid), 0);
  endtask

  task automatic t_first_miss();
    t_rp = 3; t_rcd = 3;
    send(14'h155, 14'h008);
    chk("R2 activate first", bus(), mk(3'b011, 14'h155));
    chk("R7 ready low after act", 32'(req_ready), 0);
    for (int i = 0; i < 2; i++) begin
      step();
      chk("R10 nop in rcd wait", bus(), mk(3'b111, 0));
      chk("R7 ready low in wait", 32'(req_ready), 0);
    end
    step();
    chk("R3 read after rcd", bus(), mk(3'b101, 14'h008));
    chk("R7 ready in read cycle", 32'(req_ready), 1);
    drain();
  endtask

  task automatic t_hit_window(input logic [2:0] cl, input logic [13:0] c);
    cas_lat = cl;
    send(14'h155, c);
    chk("R4 hit read next cycle", bus(), mk(3'b101, c));
    for (int k = 1; k < int'(cl); k++) begin
      step(); chk("R8 no data before latency", 32'(rd_valid), 0);
    end
    step();
    chk("R8 first beat at latency", {30'd0, rd_valid, rd_first}, 3);
    for (int k = 1; k < 4; k++) begin
      step(); chk("R8 burst beat", {30'd0, rd_valid, rd_first}, 2);
    end
    step(); chk("R8 window ends", 32'(rd_valid), 0);
    drain();
  endtask

  task automatic t_other_row(input logic [3:0] rp, input logic [3:0] rcd,
                             input logic [13:0] r, input logic [13:0] c);
    int erp, ercd;
    t_rp = rp; t_rcd = rcd;
    erp = (rp == 0) ? 1 : int'(rp);
    ercd = (rcd == 0) ? 1 : int'(rcd);
    send(r, c);
    chk("R5 precharge first", bus(), mk(3'b010, 0));
    chk("R7 ready low after pre", 32'(req_ready), 0);
    for (int i = 1; i < erp; i++) begin
      step(); chk("R10 nop in rp wait", bus(), mk(3'b111, 0));
    end
    step();
    chk(rp == 0 ? "R6 act with rp 0" : "R5 act after rp", bus(), mk(3'b011, r));
    for (int i = 1; i < ercd; i++) begin
      step(); chk("R10 nop in rcd wait", bus(), mk(3'b111, 0));
    end
    step();
    chk(rcd == 0 ? "R6 read with rcd 0" : "R3 read after rcd", bus(), mk(3'b101, c));
    drain();
  endtask

  task automatic t_truncate(input logic [13:0] r);
    cas_lat = 2;
    send(r, 14'h010);
    chk("R9 first read", bus(), mk(3'b101, 14'h010));
    req_valid = 1; req_row = r; req_col = 14'h014;
    step();
    req_valid = 0;
    chk("R9 second read back to back", bus(), mk(3'b101, 14'h014));
    step();
    chk("R9 first burst starts", {30'd0, rd_valid, rd_first}, 3);
    step();
    chk("R9 new burst marked", {30'd0, rd_valid, rd_first}, 3);
    for (int k = 1; k < 4; k++) begin
      step(); chk("R9 continuing beat", {30'd0, rd_valid, rd_first}, 2);
    end
    step(); chk("R9 window ends", 32'(rd_valid), 0);
    drain();
  endtask

  initial begin
    #1;
    repeat (3) step();
    t_reset();
    t_first_miss();
    t_hit_window(3'd2, 14'h00C);
    t_hit_window(3'd3, 14'h020);
    t_other_row(4'd2, 4'd2, 14'h0AA, 14'h004);
    t_other_row(4'd0, 4'd0, 14'h3FF, 14'h01C);
    t_truncate(14'h3FF);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule